// File: doc/BRIEF.md
# Double-Buffered Serial DAC Code Register

This block is the digital front end of a serial-input digital-to-analog converter. A host drives three wires: an active-low chip select, a serial clock and a serial data line. While chip select is low, each rising serial clock edge moves one data bit into an input shift register, most significant bit first. When chip select returns high, the shift register contents are copied into a holding register, and the holding register drives the converter code. The converter only sees a new code at the end of a frame, never a partly shifted word.

All three pins are sampled in a faster system clock domain. Each pin passes through a two-flop synchronizer, and edge detectors turn the synchronized levels into single-cycle events. The shift register is as wide as the code, so any number of bits may be sent in a frame. Older leading bits drop off the top, and only the last N bits present at the chip-select rise are loaded. A parameter selects 16-bit or 14-bit resolution, which lets the 14-bit build accept a normal two-byte frame. A one-cycle update pulse marks every load of the holding register.

Top module: `sdac_front`

## Requirements
- R1: After reset, the code output is zero and the update output is low. No load occurs until chip select makes a low-to-high transition.
- R2: While chip select is low, each rising serial clock edge shifts one bit into the shift register. The first bit sent ends up nearest the most significant end. A 16-bit frame in the 16-bit build loads exactly the word sent.
- R3: While chip select is high, serial clock edges leave the shift register unchanged. A later frame with no clock edges therefore reloads the previously loaded word.
- R4: The code output changes only on a chip-select rising edge. During a frame it keeps the previous code.
- R5: A frame longer than N bits loads only the last N bits sent, where N is 16 or 14.
- R6: In the 14-bit build, a 16-bit frame is accepted and the code becomes the final 14 bits sent.
- R7: A serial clock rising edge that reaches the block in the same synchronized cycle as the chip-select rise is not counted as a data bit.
- R8: The update output is high for exactly one system clock cycle per chip-select rise, in the cycle the new code first appears. This holds even when the new code equals the old one.
- R9: A frame with fewer than N bits, including a frame with none, still loads. The code is the previous shift register contents shifted left by the bit count, with the new bits in the low positions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4 times the serial clock rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n_i | input | 1 | Active-low chip select from the host |
| sclk_i | input | 1 | Serial clock from the host |
| sdi_i | input | 1 | Serial data from the host, most significant bit first |
| dac_code_o | output | CODE_W | Held converter code (CODE_W is 16 or 14) |
| update_o | output | 1 | One-cycle pulse when the held code is loaded |

## Verification
The bench builds two copies of the block side by side from the same three wires: one with the 16-bit default and one with the 14-bit setting. Every frame is therefore checked against both resolutions at once. This puts the two-byte frame on the 14-bit build within reach, as well as long frames where the two builds keep different tails. A software shift model of each width predicts the short and empty frames, the idle clocking with chip select high, and the strobe where the serial clock and chip select rise together.

// File: rtl/sdac_pkg.sv
`timescale 1ns/1ps
package sdac_pkg;
  // number of flops in each input synchronizer
  localparam int unsigned SYNC_DEPTH_DEF = 2;

  // positions of the pins inside the sampled pin vector
  localparam int unsigned PIN_CS   = 0;
  localparam int unsigned PIN_SCLK = 1;
  localparam int unsigned PIN_SDI  = 2;
  localparam int unsigned PIN_CNT  = 3;

  // idle pin levels used as synchronizer reset values
  localparam logic [PIN_CNT-1:0] PIN_IDLE = 3'b001;

  // code width picked by the resolution switch
  function automatic int unsigned code_width(input bit high_res);
    return high_res ? 16 : 14;
  endfunction
endpackage

// File: rtl/sdac_sync.sv
`timescale 1ns/1ps
module sdac_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL[b]}};
      else        chain <= {chain[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = chain[STAGES-1];
  end
endmodule

// File: rtl/sdac_edge.sv
`timescale 1ns/1ps
module sdac_edge #(
  parameter int unsigned W = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] s_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= RST_VAL;
    else        prev_q <= s_i;
  end

  assign rise_o = s_i & ~prev_q;

  for (genvar b = 0; b < W; b++) begin : g_chk
    // R2
    rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o[b] |=> !rise_o[b]);
  end
endmodule

// File: rtl/sdac_shift.sv
`timescale 1ns/1ps
module sdac_shift #(
  parameter int unsigned CODE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_rise_i,
  input  logic              cs_hi_i,
  input  logic              sdi_i,
  output logic [CODE_W-1:0] sr_o,
  output logic              shift_o
);
  logic [CODE_W-1:0] sr_q;

  function automatic logic [CODE_W-1:0] push_bit(input logic [CODE_W-1:0] cur,
                                                 input logic b);
    return {cur[CODE_W-2:0], b};
  endfunction

  // a bit counts only while chip select is low in the same cycle
  assign shift_o = sclk_rise_i & ~cs_hi_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sr_q <= '0;
    else if (shift_o) sr_q <= push_bit(sr_q, sdi_i);
  end

  assign sr_o = sr_q;

  // R3
  idle_no_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_hi_i |=> $stable(sr_q));

  // R2
  shift_msb_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift_o |=> (sr_q[0] == $past(sdi_i)) && (sr_q[CODE_W-1:1] == $past(sr_q[CODE_W-2:0])));
endmodule

// File: rtl/sdac_hold.sv
`timescale 1ns/1ps
module sdac_hold #(
  parameter int unsigned CODE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [CODE_W-1:0] sr_i,
  output logic [CODE_W-1:0] code_o,
  output logic              update_o
);
  logic [CODE_W-1:0] code_q;
  logic              upd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      upd_q  <= 1'b0;
    end else begin
      upd_q <= load_i;
      if (load_i) code_q <= sr_i;
    end
  end

  assign code_o   = code_q;
  assign update_o = upd_q;

  // R4
  code_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(code_q));

  // R5
  code_takes_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> code_q == $past(sr_i));

  // R8
  upd_follows_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> upd_q);

  // R8
  upd_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_q |=> !upd_q);
endmodule

// File: rtl/sdac_front.sv
`timescale 1ns/1ps
module sdac_front
  import sdac_pkg::*;
#(
  parameter bit          HIGH_RES   = 1'b1,
  parameter int unsigned SYNC_DEPTH = SYNC_DEPTH_DEF,
  localparam int unsigned CODE_W    = code_width(HIGH_RES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n_i,
  input  logic              sclk_i,
  input  logic              sdi_i,
  output logic [CODE_W-1:0] dac_code_o,
  output logic              update_o
);
  logic [PIN_CNT-1:0] pins_raw, pins_s;
  logic [1:0]         edge_lvl, edge_rise;
  logic               cs_hi, cs_rise, sclk_rise, sdi_s, shift_w;
  logic [CODE_W-1:0]  sr_w;

  assign pins_raw[PIN_CS]   = cs_n_i;
  assign pins_raw[PIN_SCLK] = sclk_i;
  assign pins_raw[PIN_SDI]  = sdi_i;

  sdac_sync #(.W(PIN_CNT), .STAGES(SYNC_DEPTH), .RST_VAL(PIN_IDLE)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(pins_raw), .q_o(pins_s));

  assign cs_hi    = pins_s[PIN_CS];
  assign sdi_s    = pins_s[PIN_SDI];
  assign edge_lvl = {pins_s[PIN_SCLK], pins_s[PIN_CS]};

  sdac_edge #(.W(2), .RST_VAL(2'b01)) u_edge (
    .clk(clk), .rst_n(rst_n), .s_i(edge_lvl), .rise_o(edge_rise));

  assign cs_rise   = edge_rise[0];
  assign sclk_rise = edge_rise[1];

  sdac_shift #(.CODE_W(CODE_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .sclk_rise_i(sclk_rise), .cs_hi_i(cs_hi),
    .sdi_i(sdi_s), .sr_o(sr_w), .shift_o(shift_w));

  sdac_hold #(.CODE_W(CODE_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .load_i(cs_rise), .sr_i(sr_w),
    .code_o(dac_code_o), .update_o(update_o));

  // R7
  no_bit_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise |-> !shift_w);
endmodule

// File: tb/sim_sdac_front.sv
`timescale 1ns/1ps
module sim_sdac_front;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, cs_n, sclk, sdi;
  logic [15:0] code16;
  logic [13:0] code14;
  logic upd0, upd1;

  sdac_front #(.HIGH_RES(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .sclk_i(sclk), .sdi_i(sdi),
    .dac_code_o(code16), .update_o(upd0));
  sdac_front #(.HIGH_RES(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .sclk_i(sclk), .sdi_i(sdi),
    .dac_code_o(code14), .update_o(upd1));

  localparam int NVEC = 8;
  localparam logic [31:0] VDAT [NVEC] = '{32'h0000A5C3, 32'h0000FFFF, 32'h00123456,
    32'h0000007E, 32'h00000000, 32'h00000000, 32'h00000000, 32'h000ABCDE};
  localparam int VLEN [NVEC] = '{16, 16, 24, 8, 0, 16, 16, 20};

  int n_chk = 0, n_bad = 0;
  int pc0 = 0, pc1 = 0, dbl0 = 0, dbl1 = 0;
  logic prev0 = 1'b0, prev1 = 1'b0;
  logic [15:0] m16 = '0;
  logic [13:0] m14 = '0;

  always @(negedge clk) begin
    if (upd0) pc0++;
    if (upd1) pc1++;
    if (upd0 && prev0) dbl0++;
    if (upd1 && prev1) dbl1++;
    prev0 = upd0;
    prev1 = upd1;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    sdi = b;
    tick(4);
    sclk = 1'b1;
    tick(4);
    sclk = 1'b0;
    m16 = {m16[14:0], b};
    m14 = {m14[12:0], b};
  endtask

  task automatic frame_begin();
    cs_n = 1'b0;
    tick(4);
  endtask

  task automatic frame_end();
    tick(2);
    cs_n = 1'b1;
    tick(10);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b0; sdi = 1'b0;
    tick(5);
    // R1 reset state
    check("R1", {16'h0, code16}, 32'h0);
    check("R1", {18'h0, code14}, 32'h0);
    check("R1", {31'h0, upd0}, 32'h0);
    rst_n = 1'b1;
    tick(8);
    check("R1", pc0, 0);
    check("R1", pc1, 0);

    for (int i = 0; i < NVEC; i++) begin
      int p0, p1;
      logic [15:0] old16;
      string tag;
      p0 = pc0; p1 = pc1; old16 = m16;
      tag = (VLEN[i] > 16) ? "R5" : ((VLEN[i] < 16) ? "R9" : "R2");
      frame_begin();
      for (int j = VLEN[i] - 1; j >= 0; j--) begin
        send_bit(VDAT[i][j]);
        if (i == 2 && j == 8) begin
          // R4 code held during frame
          check("R4", {16'h0, code16}, {16'h0, old16});
          check("R4", pc0, p0);
        end
      end
      frame_end();
      check(tag, {16'h0, code16}, {16'h0, m16});
      // R6 14-bit build keeps the final 14 bits
      check((VLEN[i] >= 16) ? "R6" : "R9", {18'h0, code14}, {18'h0, m14});
      // R8 one update per frame, also for repeated code
      check("R8", pc0, p0 + 1);
      check("R8", pc1, p1 + 1);
    end

    // R3: serial clock with chip select high is ignored
    begin
      logic [15:0] keep16;
      int p0;
      keep16 = m16; p0 = pc0;
      for (int k = 0; k < 10; k++) begin
        sdi = k[0];
        tick(4);
        sclk = 1'b1;
        tick(4);
        sclk = 1'b0;
      end
      tick(6);
      check("R3", {16'h0, code16}, {16'h0, keep16});
      check("R3", pc0, p0);
      frame_begin();
      frame_end();
      check("R3", {16'h0, code16}, {16'h0, m16});
      check("R3", {18'h0, code14}, {18'h0, m14});
    end

    // R7: clock edge together with chip-select rise is not a bit
    frame_begin();
    for (int k = 0; k < 15; k++) send_bit(k[1]);
    sdi = 1'b1;
    tick(4);
    sclk = 1'b1;
    cs_n = 1'b1;
    tick(4);
    sclk = 1'b0;
    tick(10);
    check("R7", {16'h0, code16}, {16'h0, m16});
    check("R7", {18'h0, code14}, {18'h0, m14});

    // R8 no pulse longer than one cycle
    check("R8", dbl0, 0);
    check("R8", dbl1, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule